// File: doc/BRIEF.md
# Debug Communications Channel

This block is a two-way 32-bit mailbox between an external debugger and the processor core. The debugger reaches it through a small register window. Each access is a one-cycle strobe that carries an address, a write flag and a word. The core reaches it through a simple port with a one-bit address: either the mailbox word or the channel status.

One word travels in each direction. The host-to-target word is written by the debugger and read by the core. Its pending flag is set by the debugger's write and cleared by the core's read. The target-to-host word is written by the core and read by the debugger. Its valid flag is set by the core's write and cleared by the debugger's read of the data address. That read is destructive, so a debugger that streams words in must point its final access at the status address to avoid consuming an extra word.

Both flags and a fixed version number can be read from either side, and reading them has no side effect. Words may be streamed on back-to-back strobes with no handshake between them. Everything runs on one clock: both sides present strobes that are synchronous to it.

Top module: `dcc_mailbox`

## Requirements
- R1: After reset both flags are 0, both stored words are 0, and both read-data outputs are 0.
- R2: A debugger write strobe to address 5 loads the host-to-target word and sets the pending flag, which is bit 0 of the status word, from the next cycle on.
- R3: A core read with core address 0 returns the host-to-target word on `core_rdata_o` one cycle later and clears the pending flag at the same edge.
- R4: A core write with core address 0 loads the target-to-host word and sets the valid flag, which is bit 1 of the status word, from the next cycle on.
- R5: A debugger read of address 5 returns the target-to-host word on `dbg_rdata_o` one cycle later and clears the valid flag at the same edge on which the word is captured.
- R6: The status word is {VERSION in bits 31:28, zeros in bits 27:2, valid flag in bit 1, pending flag in bit 0}. VERSION defaults to 6. The debugger reads it at address 4 and the core reads it with core address 1. Reading it changes neither flag.
- R7: A write into a direction whose flag is already set replaces the stored word and leaves the flag set.
- R8: When a write and a consuming read of the same direction happen in the same cycle, the reader gets the old word and the new word is stored with its flag set.
- R9: Debugger writes to any address other than 5, and core writes with core address 1, change no state. Debugger reads of any address other than 4 or 5 return 0.
- R10: Read data is held on each read-data output until the next read on that side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dbg_req_i | input | 1 | Debugger access strobe |
| dbg_we_i | input | 1 | Debugger access is a write |
| dbg_addr_i | input | 5 | Debugger register address |
| dbg_wdata_i | input | 32 | Debugger write word |
| dbg_rdata_o | output | 32 | Debugger read word, registered |
| core_req_i | input | 1 | Core access strobe |
| core_we_i | input | 1 | Core access is a write |
| core_addr_i | input | 1 | Core select: 0 mailbox word, 1 status |
| core_wdata_i | input | 32 | Core write word |
| core_rdata_o | output | 32 | Core read word, registered |

## Verification
Directed sequences run each direction through its normal fill-and-drain cycle. Each read of the status word tells a flag that was set apart from one that was cleared. Overwrites and same-cycle write/consume pairs are applied to both directions; they separate a design that lets the consume win from one that lets the load win, and show whether the reader gets the old word or the new one. Writes to the status address and to unmapped addresses show whether stray accesses change any state. A long random mix of both sides' strobes, biased toward the two live addresses, then covers simultaneous traffic, and every cycle's outputs are compared against a bench model of the two slots.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  localparam int unsigned DBG_CTRL_ADDR = 4;
  localparam int unsigned DBG_DATA_ADDR = 5;
  localparam int unsigned NUM_DIR       = 2;
  localparam int unsigned DIR_H2T       = 0;
  localparam int unsigned DIR_T2H       = 1;

  typedef enum logic {
    CORE_SEL_DATA = 1'b0,
    CORE_SEL_CTRL = 1'b1
  } core_sel_e;
endpackage

// File: rtl/dcc_slot.sv
module dcc_slot #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              take_i,
  output logic [DATA_W-1:0] word_o,
  output logic              full_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o <= '0;
      full_o <= 1'b0;
    end else begin
      if (load_i) word_o <= data_i;
      // load beats a same-cycle consume
      if (load_i)      full_o <= 1'b1;
      else if (take_i) full_o <= 1'b0;
    end
  end
endmodule

// File: rtl/dcc_dbg_port.sv
module dcc_dbg_port #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned CTRL_ADDR = 4,
  parameter int unsigned DATA_ADDR = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] ctrl_i,
  input  logic [DATA_W-1:0] word_i,
  output logic              load_o,
  output logic              take_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic hit_data, hit_ctrl, rd;
  logic [DATA_W-1:0] rd_mux;

  assign hit_data = (addr_i == ADDR_W'(DATA_ADDR));
  assign hit_ctrl = (addr_i == ADDR_W'(CTRL_ADDR));
  assign rd       = req_i && !we_i;
  assign load_o   = req_i && we_i && hit_data;
  assign take_o   = rd && hit_data;

  always_comb begin
    rd_mux = '0;
    if (hit_data)      rd_mux = word_i;
    else if (hit_ctrl) rd_mux = ctrl_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_o <= '0;
    else if (rd)  rdata_o <= rd_mux;
  end
endmodule

// File: rtl/dcc_core_port.sv
module dcc_core_port
  import dcc_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] ctrl_i,
  input  logic [DATA_W-1:0] word_i,
  output logic              load_o,
  output logic              take_o,
  output logic [DATA_W-1:0] rdata_o
);
  core_sel_e sel;
  logic rd;

  assign sel    = core_sel_e'(addr_i);
  assign rd     = req_i && !we_i;
  assign load_o = req_i && we_i && (sel == CORE_SEL_DATA);
  assign take_o = rd && (sel == CORE_SEL_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (rd) rdata_o <= (sel == CORE_SEL_DATA) ? word_i : ctrl_i;
  end
endmodule

// File: rtl/dcc_mailbox.sv
module dcc_mailbox
  import dcc_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned VER_W   = 4,
  parameter int unsigned VERSION = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dbg_req_i,
  input  logic              dbg_we_i,
  input  logic [ADDR_W-1:0] dbg_addr_i,
  input  logic [DATA_W-1:0] dbg_wdata_i,
  output logic [DATA_W-1:0] dbg_rdata_o,
  input  logic              core_req_i,
  input  logic              core_we_i,
  input  logic              core_addr_i,
  input  logic [DATA_W-1:0] core_wdata_i,
  output logic [DATA_W-1:0] core_rdata_o
);
  localparam int unsigned RSV_W = DATA_W - VER_W - 2;

  logic [NUM_DIR-1:0]             slot_load, slot_take, slot_full;
  logic [NUM_DIR-1:0][DATA_W-1:0] slot_din, slot_word;
  logic [DATA_W-1:0]              ctrl_word;
  logic                           h2t_full, t2h_full;
  logic dbg_load, dbg_take, core_load, core_take;

  assign h2t_full  = slot_full[DIR_H2T];
  assign t2h_full  = slot_full[DIR_T2H];
  assign ctrl_word = {VER_W'(VERSION), {RSV_W{1'b0}}, t2h_full, h2t_full};

  assign slot_load[DIR_H2T] = dbg_load;
  assign slot_take[DIR_H2T] = core_take;
  assign slot_din[DIR_H2T]  = dbg_wdata_i;
  assign slot_load[DIR_T2H] = core_load;
  assign slot_take[DIR_T2H] = dbg_take;
  assign slot_din[DIR_T2H]  = core_wdata_i;

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_slot
    dcc_slot #(.DATA_W(DATA_W)) i_slot (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (slot_load[d]),
      .data_i (slot_din[d]),
      .take_i (slot_take[d]),
      .word_o (slot_word[d]),
      .full_o (slot_full[d])
    );
  end

  dcc_dbg_port #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .CTRL_ADDR(DBG_CTRL_ADDR), .DATA_ADDR(DBG_DATA_ADDR)
  ) i_dbg_port (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (dbg_req_i),
    .we_i    (dbg_we_i),
    .addr_i  (dbg_addr_i),
    .ctrl_i  (ctrl_word),
    .word_i  (slot_word[DIR_T2H]),
    .load_o  (dbg_load),
    .take_o  (dbg_take),
    .rdata_o (dbg_rdata_o)
  );

  dcc_core_port #(.DATA_W(DATA_W)) i_core_port (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (core_req_i),
    .we_i    (core_we_i),
    .addr_i  (core_addr_i),
    .ctrl_i  (ctrl_word),
    .word_i  (slot_word[DIR_H2T]),
    .load_o  (core_load),
    .take_o  (core_take),
    .rdata_o (core_rdata_o)
  );
endmodule

// File: rtl/dcc_mailbox_chk.sv
module dcc_mailbox_chk #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned VER_W   = 4,
  parameter int unsigned VERSION = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dbg_req_i,
  input logic              dbg_we_i,
  input logic [ADDR_W-1:0] dbg_addr_i,
  input logic [DATA_W-1:0] dbg_rdata_o,
  input logic              core_req_i,
  input logic              core_we_i,
  input logic              core_addr_i,
  input logic              h2t_full,
  input logic              t2h_full
);
  logic dbg_wr_data, dbg_rd_data, dbg_rd_ctrl, core_wr_data, core_rd_data;
  assign dbg_wr_data  = dbg_req_i && dbg_we_i && (dbg_addr_i == ADDR_W'(5));
  assign dbg_rd_data  = dbg_req_i && !dbg_we_i && (dbg_addr_i == ADDR_W'(5));
  assign dbg_rd_ctrl  = dbg_req_i && !dbg_we_i && (dbg_addr_i == ADDR_W'(4));
  assign core_wr_data = core_req_i && core_we_i && !core_addr_i;
  assign core_rd_data = core_req_i && !core_we_i && !core_addr_i;

  p_dbg_wr_sets_pend_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_wr_data |=> h2t_full);
  p_core_rd_clears_pend_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_rd_data && !dbg_wr_data |=> !h2t_full);
  p_core_wr_sets_valid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_wr_data |=> t2h_full);
  p_dbg_rd_clears_valid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_rd_data && !core_wr_data |=> !t2h_full);
  p_ctrl_rd_no_effect_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_rd_ctrl && !core_req_i |=> $stable(h2t_full) && $stable(t2h_full));
  p_ctrl_format_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_rd_ctrl |=> dbg_rdata_o[DATA_W-1 -: VER_W] == VER_W'(VERSION)
                    && dbg_rdata_o[DATA_W-VER_W-1:2] == '0);
  p_rdata_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dbg_req_i && !dbg_we_i) |=> $stable(dbg_rdata_o));
endmodule

bind dcc_mailbox dcc_mailbox_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .VER_W(VER_W), .VERSION(VERSION)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .dbg_req_i   (dbg_req_i),
  .dbg_we_i    (dbg_we_i),
  .dbg_addr_i  (dbg_addr_i),
  .dbg_rdata_o (dbg_rdata_o),
  .core_req_i  (core_req_i),
  .core_we_i   (core_we_i),
  .core_addr_i (core_addr_i),
  .h2t_full    (h2t_full),
  .t2h_full    (t2h_full)
);

// File: tb/test_dcc_mailbox.sv
module test_dcc_mailbox;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] VER = 4'd6;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        dbg_req_i = 0, dbg_we_i = 0, core_req_i = 0, core_we_i = 0, core_addr_i = 0;
  logic [4:0]  dbg_addr_i = '0;
  logic [31:0] dbg_wdata_i = '0, core_wdata_i = '0, dbg_rdata_o, core_rdata_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] m_h2t = '0, m_t2h = '0, m_drd = '0, m_crd = '0;
  logic        m_r = 0, m_w = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dcc_mailbox i_dcc_mailbox (.*);

  function automatic logic [31:0] ctrl_exp(logic r, logic w);
    return {VER, 26'b0, w, r};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one cycle of both sides, update the model, check both read outputs
  task automatic step(string req, logic dr, logic dw, logic [4:0] da, logic [31:0] dd,
                      logic cr, logic cw, logic ca, logic [31:0] cd);
    logic hl, ht, tl, tt;
    dbg_req_i = dr; dbg_we_i = dw; dbg_addr_i = da; dbg_wdata_i = dd;
    core_req_i = cr; core_we_i = cw; core_addr_i = ca; core_wdata_i = cd;
    if (dr && !dw) m_drd = (da == 5) ? m_t2h : (da == 4) ? ctrl_exp(m_r, m_w) : 32'h0;
    if (cr && !cw) m_crd = ca ? ctrl_exp(m_r, m_w) : m_h2t;
    hl = dr && dw && da == 5;  ht = cr && !cw && !ca;
    tl = cr && cw && !ca;      tt = dr && !dw && da == 5;
    if (hl) m_h2t = dd;
    if (tl) m_t2h = cd;
    m_r = hl ? 1'b1 : ht ? 1'b0 : m_r;
    m_w = tl ? 1'b1 : tt ? 1'b0 : m_w;
    @(posedge clk_i); #1;
    chk(req, dbg_rdata_o, m_drd);
    chk(req, core_rdata_o, m_crd);
    @(negedge clk_i);
  endtask

  task automatic dw(string q, logic [4:0] a, logic [31:0] d); step(q, 1, 1, a, d, 0, 0, 0, 0); endtask
  task automatic dr(string q, logic [4:0] a);                 step(q, 1, 0, a, 0, 0, 0, 0, 0); endtask
  task automatic cw(string q, logic a, logic [31:0] d);       step(q, 0, 0, 0, 0, 1, 1, a, d); endtask
  task automatic cr(string q, logic a);                       step(q, 0, 0, 0, 0, 1, 0, a, 0); endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0dcc_5eed));
    repeat (3) @(negedge clk_i);
    chk("R1", dbg_rdata_o, 32'h0);
    chk("R1", core_rdata_o, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    dr("R1 R6", 4);      chk("R6 dbg ctrl after reset", dbg_rdata_o, 32'h6000_0000);
    cr("R1 R6", 1);      chk("R6 core ctrl after reset", core_rdata_o, 32'h6000_0000);
    // host to target
    dw("R2", 5, 32'hA5A5_0001);
    dr("R2", 4);         chk("R2 pend set", dbg_rdata_o, 32'h6000_0001);
    cr("R3", 0);         chk("R3 word", core_rdata_o, 32'hA5A5_0001);
    cr("R3", 1);         chk("R3 pend clear", core_rdata_o, 32'h6000_0000);
    // target to host
    cw("R4", 0, 32'h1234_5678);
    cr("R4", 1);         chk("R4 valid set", core_rdata_o, 32'h6000_0002);
    dr("R6", 4); dr("R6", 4);
    chk("R6 no side effect", dbg_rdata_o, 32'h6000_0002);
    dr("R5", 5);         chk("R5 word", dbg_rdata_o, 32'h1234_5678);
    dr("R5", 4);         chk("R5 valid clear", dbg_rdata_o, 32'h6000_0000);
    step("R10", 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R10 hold", dbg_rdata_o, 32'h6000_0000);
    // overwrite
    dw("R7", 5, 32'hC0C0_0001); dw("R7", 5, 32'hD0D0_0002);
    cr("R7", 0);         chk("R7 h2t replaced", core_rdata_o, 32'hD0D0_0002);
    cw("R7", 0, 32'h1111_0001); cw("R7", 0, 32'h2222_0002);
    dr("R7", 5);         chk("R7 t2h replaced", dbg_rdata_o, 32'h2222_0002);
    // same-cycle load and consume
    dw("R8", 5, 32'hE0E0_0001);
    step("R8", 1, 1, 5, 32'hF0F0_0002, 1, 0, 0, 0);
    chk("R8 h2t old word", core_rdata_o, 32'hE0E0_0001);
    cr("R8", 1);         chk("R8 pend kept", core_rdata_o, 32'h6000_0001);
    cr("R8", 0);         chk("R8 h2t new word", core_rdata_o, 32'hF0F0_0002);
    cw("R8", 0, 32'h3333_0001);
    step("R8", 1, 0, 5, 0, 1, 1, 0, 32'h4444_0002);
    chk("R8 t2h old word", dbg_rdata_o, 32'h3333_0001);
    dr("R8", 4);         chk("R8 valid kept", dbg_rdata_o, 32'h6000_0002);
    dr("R8", 5);         chk("R8 t2h new word", dbg_rdata_o, 32'h4444_0002);
    // ignored accesses
    dw("R9", 4, 32'hFFFF_FFFF); dw("R9", 8, 32'hBAD0_0008); cw("R9", 1, 32'hFFFF_FFFF);
    dr("R9", 4);         chk("R9 flags untouched", dbg_rdata_o, 32'h6000_0000);
    cr("R9", 0);         chk("R9 h2t untouched", core_rdata_o, 32'hF0F0_0002);
    dr("R9", 5);         chk("R9 t2h untouched", dbg_rdata_o, 32'h4444_0002);
    dr("R9", 8);         chk("R9 unmapped", dbg_rdata_o, 32'h0);
    dr("R9", 31);        chk("R9 unmapped", dbg_rdata_o, 32'h0);
    // random mix, biased to live addresses
    for (int i = 0; i < 2000; i++) begin
      int unsigned s = $urandom % 8;
      logic [4:0] a = (s < 3) ? 5'd5 : (s < 5) ? 5'd4 : 5'($urandom);
      step("RND R2 R3 R4 R5 R7 R8", 1'($urandom), 1'($urandom), a, $urandom,
           1'($urandom), 1'($urandom), 1'($urandom), $urandom);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule